// File: doc/BRIEF.md
# Microwire Serial Memory Host Controller

This block is the master side of a three-wire serial memory link. A client posts a command (a 2-bit opcode, a word address, a write word and a word count) on a valid/ready handshake. The controller then raises chip select and derives the serial clock from the system clock through a divider. It shifts out a start bit, the opcode and the address, followed by the data word when the command is a write. Returned data is sampled on the falling serial clock edge. The filler zero that the memory emits ahead of the first word is dropped, and each assembled word is handed to the client on a one-cycle strobe.

A read may ask for several words. Chip select then stays high and the clock keeps running, and the memory streams consecutive words with no filler between them, wrapping from the top address back to zero. Writes and erases end differently. After the last bit, chip select is held low for a programmed minimum time so the memory starts its internal program cycle. The controller then reselects the device and watches the data line until it reads high. A cycle counter bounds that wait and reports a timeout when it runs out. Every command ends with a single-cycle done pulse, and a new request is taken only when the controller is idle.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, chip select and the serial clock are low, the request port is ready, and done, the read strobe and the timeout flag are low.
- R2: The serial clock toggles only while chip select is high. Each high phase lasts exactly HALF_DIV system cycles, where HALF_DIV is the ceiling of SYS_CLK_HZ / (2 * SK_MAX_HZ).
- R3: A frame is sent as a 1 start bit, then the opcode (high bit first), then ADDR_W address bits MSB first, then, for opcode 01 (write) only, DATA_W data bits MSB first. The data-in line changes only while the serial clock is low.
- R4: For opcode 10 (read), the bit sampled on the falling edge of the last address clock is a filler bit and is discarded. The next DATA_W falling-edge samples form the word MSB first, so a one-word read takes exactly 3 + ADDR_W + DATA_W serial clocks.
- R5: A read returns max(count,1) words, each on its own one-cycle read strobe. Chip select stays high across all of them, the clocks run back to back with no extra filler clock, and the memory address wraps past the top to 0. The read strobe is never high while the request port is ready.
- R6: After the final bit of opcode 01 (write) or opcode 11 (erase), chip select stays low for at least CS_MIN_CYC system cycles with the serial clock low, and is then raised again for polling.
- R7: While polling, the command completes on the first cycle the data-out line is high, with the timeout flag low. If data-out stays low for POLL_LIMIT cycles, the command completes with the timeout flag high. The timeout flag is only ever high together with done.
- R8: Done is high for exactly one cycle per command. The request port is ready only when the controller is idle, and never in the same cycle as done.
- R9: Opcode 00 sends only the 3 + ADDR_W header bits. It then completes without polling and without any read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request present |
| reqReady | output | 1 | Controller idle and taking a request |
| reqOp | input | 2 | Opcode: 10 read, 01 write, 11 erase, 00 header only |
| reqAddr | input | ADDR_W | Starting word address |
| reqData | input | DATA_W | Word to write |
| reqCount | input | CNT_W | Number of words to read (0 treated as 1) |
| rdValid | output | 1 | One-cycle strobe for a returned word |
| rdData | output | DATA_W | Returned word |
| done | output | 1 | One-cycle end-of-command pulse |
| timeoutErr | output | 1 | Set with done when polling ran out |
| mwCs | output | 1 | Chip select to the memory |
| mwSk | output | 1 | Serial clock to the memory |
| mwDi | output | 1 | Serial data to the memory |
| mwDo | input | 1 | Serial data from the memory |

## Verification
The bench builds the controller with an 8 MHz system clock against a 1 MHz serial limit, which gives a four-cycle half period and keeps each bit short. It uses a 6-bit address, so a multi-word read starting near address 62 crosses the wrap to zero. The deselect minimum is set to 5 cycles and the poll limit to 40, so a memory model that never reports ready drives the timeout path to completion in a few dozen cycles. A behavioural memory in the bench listens on the serial pins and inserts the filler bit, which lets write data be checked end to end by reading it back.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

  typedef enum logic [1:0] {
    OP_MISC  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mwOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic run;
    logic cs;
    logic rxEn;
    logic waitEn;
    logic waitClr;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic txEnd;
    logic wordDone;
    logic deselDone;
    logic pollExpired;
  } dpSts_t;

endpackage

// File: rtl/mw_host_datapath.sv
module mw_host_datapath
  import mw_host_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 25,
  parameter int CS_MIN_CYC = 13,
  parameter int POLL_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              mwDo,
  output dpSts_t            sts,
  output logic              mwSk,
  output logic              mwDi,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int HDR_W    = 3 + ADDR_W;
  localparam int FRAME_W  = HDR_W + DATA_W;
  localparam int DIV_W    = $clog2(HALF_DIV + 1);
  localparam int TXC_W    = $clog2(FRAME_W + 1);
  localparam int RXC_W    = $clog2(DATA_W + 1);
  localparam int WAIT_MAX = (CS_MIN_CYC > POLL_LIMIT) ? CS_MIN_CYC : POLL_LIMIT;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  // serial clock divider
  logic [DIV_W-1:0] divCnt;
  logic             skReg;
  logic             tick;
  logic             fallTick;

  assign tick     = ctl.run && (divCnt == DIV_W'(HALF_DIV - 1));
  assign fallTick = tick && skReg;

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      divCnt <= '0;
      skReg  <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      skReg  <= ~skReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign mwSk = skReg;

  // transmit shifter: header plus optional write word
  logic [FRAME_W-1:0] txShift;
  logic [TXC_W-1:0]   txLeft;
  logic               isWrite;

  assign isWrite = (reqOp == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      txLeft  <= '0;
    end else if (ctl.load) begin
      txShift <= {1'b1, reqOp, reqAddr, (isWrite ? reqData : {DATA_W{1'b0}})};
      txLeft  <= isWrite ? TXC_W'(FRAME_W - 1) : TXC_W'(HDR_W - 1);
    end else if (fallTick) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (txLeft != '0) txLeft <= txLeft - 1'b1;
    end
  end

  assign mwDi      = txShift[FRAME_W-1];
  assign sts.txEnd = fallTick && (txLeft == '0);

  // receive shifter, sampled on the falling serial edge
  logic [DATA_W-1:0] rxShift;
  logic [RXC_W-1:0]  rxCnt;

  assign sts.wordDone = ctl.rxEn && fallTick && (rxCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxCnt   <= RXC_W'(DATA_W - 1);
    end else if (!ctl.rxEn) begin
      rxCnt   <= RXC_W'(DATA_W - 1);
    end else if (fallTick) begin
      rxShift <= {rxShift[DATA_W-2:0], mwDo};
      rxCnt   <= (rxCnt == '0) ? RXC_W'(DATA_W - 1) : rxCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= sts.wordDone;
      if (sts.wordDone) rdData <= {rxShift[DATA_W-2:0], mwDo};
    end
  end

  // shared wait counter for deselect time and poll timeout
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.waitEn || ctl.waitClr) begin
      waitCnt <= '0;
    end else if (waitCnt != WAIT_W'(WAIT_MAX)) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign sts.deselDone   = (waitCnt == WAIT_W'(CS_MIN_CYC - 1));
  assign sts.pollExpired = (waitCnt == WAIT_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/mw_host_ctrl.sv
module mw_host_ctrl
  import mw_host_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             mwDo,
  input  dpSts_t           sts,
  output dpCtl_t           ctl,
  output logic             reqReady,
  output logic             done,
  output logic             timeoutErr
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_READ,
    ST_DESEL,
    ST_POLL,
    ST_FINISH
  } state_e;

  state_e           state, stateNxt;
  mwOp_e            opQ;
  logic [CNT_W-1:0] wordsLeft;
  logic             errQ;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    case (state)
      ST_IDLE: begin
        ctl.load = reqValid;
        if (reqValid) stateNxt = ST_SHIFT;
      end
      ST_SHIFT: begin
        ctl.run = 1'b1;
        ctl.cs  = 1'b1;
        if (sts.txEnd) begin
          if (opQ == OP_READ)      stateNxt = ST_READ;
          else if (opQ == OP_MISC) stateNxt = ST_FINISH;
          else                     stateNxt = ST_DESEL;
        end
      end
      ST_READ: begin
        ctl.run  = 1'b1;
        ctl.cs   = 1'b1;
        ctl.rxEn = 1'b1;
        if (sts.wordDone && wordsLeft == CNT_W'(1)) stateNxt = ST_FINISH;
      end
      ST_DESEL: begin
        ctl.waitEn = 1'b1;
        if (sts.deselDone) begin
          ctl.waitClr = 1'b1;
          stateNxt    = ST_POLL;
        end
      end
      ST_POLL: begin
        ctl.cs     = 1'b1;
        ctl.waitEn = 1'b1;
        if (mwDo || sts.pollExpired) stateNxt = ST_FINISH;
      end
      ST_FINISH: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opQ       <= OP_MISC;
      wordsLeft <= '0;
      errQ      <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && reqValid) begin
        opQ       <= mwOp_e'(reqOp);
        wordsLeft <= (reqCount == '0) ? CNT_W'(1) : reqCount;
        errQ      <= 1'b0;
      end
      if (state == ST_READ && sts.wordDone) wordsLeft <= wordsLeft - 1'b1;
      if (state == ST_POLL && !mwDo && sts.pollExpired) errQ <= 1'b1;
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign done       = (state == ST_FINISH);
  assign timeoutErr = done && errQ;

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_host_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50000000,
  parameter int SK_MAX_HZ  = 1000000,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int CS_MIN_CYC = 13,
  parameter int POLL_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timeoutErr,
  output logic              mwCs,
  output logic              mwSk,
  output logic              mwDi,
  input  logic              mwDo
);

  localparam int HALF_RAW = (SYS_CLK_HZ + 2 * SK_MAX_HZ - 1) / (2 * SK_MAX_HZ);
  localparam int HALF_DIV = (HALF_RAW < 1) ? 1 : HALF_RAW;

  dpCtl_t ctl;
  dpSts_t sts;

  mw_host_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqCount   (reqCount),
    .mwDo       (mwDo),
    .sts        (sts),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  mw_host_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .HALF_DIV   (HALF_DIV),
    .CS_MIN_CYC (CS_MIN_CYC),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqOp   (reqOp),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .mwDo    (mwDo),
    .sts     (sts),
    .mwSk    (mwSk),
    .mwDi    (mwDi),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign mwCs = ctl.cs;

endmodule

// File: rtl/mw_host_checker.sv
module mw_host_checker #(
  parameter int HALF_DIV = 25
) (
  input logic clk,
  input logic rstN,
  input logic mwCs,
  input logic mwSk,
  input logic mwDi,
  input logic done,
  input logic reqReady,
  input logic rdValid,
  input logic timeoutErr
);

  logic        skPrev;
  logic [15:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skPrev  <= 1'b0;
      holdCnt <= '0;
    end else begin
      skPrev <= mwSk;
      if (mwSk != skPrev)         holdCnt <= 16'd1;
      else if (holdCnt != 16'hFFFF) holdCnt <= holdCnt + 16'd1;
    end
  end

  assert_sk_needs_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !mwCs |-> !mwSk);

  assert_sk_high_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (skPrev && !mwSk) |-> (holdCnt == 16'(HALF_DIV)));

  assert_di_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mwSk && $past(mwSk)) |-> $stable(mwDi));

  assert_rd_not_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_ready_vs_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && reqReady));

endmodule

bind mw_eeprom_host mw_host_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .mwCs       (mwCs),
  .mwSk       (mwSk),
  .mwDi       (mwDi),
  .done       (done),
  .reqReady   (reqReady),
  .rdValid    (rdValid),
  .timeoutErr (timeoutErr)
);

// File: tb/test_mw_eeprom_host.sv
module test_mw_eeprom_host;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int CNT_W      = 8;
  localparam int CS_MIN     = 5;
  localparam int POLL_LIM   = 40;
  localparam int HALF       = 4;   // 8 MHz / (2 * 1 MHz)
  localparam int BUSY       = 30;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [1:0]        reqOp = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic [CNT_W-1:0]  reqCount = '0;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic              done;
  logic              timeoutErr;
  logic              mwCs, mwSk, mwDi, mwDo;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_eeprom_host #(
    .SYS_CLK_HZ (8000000),
    .SK_MAX_HZ  (1000000),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .CS_MIN_CYC (CS_MIN),
    .POLL_LIMIT (POLL_LIM)
  ) i_mw_eeprom_host (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqReady (reqReady),
    .reqOp (reqOp), .reqAddr (reqAddr), .reqData (reqData), .reqCount (reqCount),
    .rdValid (rdValid), .rdData (rdData), .done (done), .timeoutErr (timeoutErr),
    .mwCs (mwCs), .mwSk (mwSk), .mwDi (mwDi), .mwDo (mwDo)
  );

  function automatic logic [15:0] initWord(input int i);
    return 16'(i * 16'h0913 + 16'h2B07);
  endfunction

  // ---------------- behavioural serial memory ----------------
  logic [15:0] mem [DEPTH];
  logic        skP, csP;
  int          hdrCnt, wrCnt, rdBit, frameBits, lastFrameBits, busyLeft;
  logic [8:0]  hdrBits, lastHdr;
  logic [15:0] wrBits;
  logic        reading, doReg;
  logic [5:0]  rdAddr;
  logic        stuck = 1'b0;

  assign mwDo = mwCs && (reading ? doReg : (hdrCnt == 0 && busyLeft == 0 && !stuck));

  always @(posedge clk) begin
    skP <= mwSk;
    csP <= mwCs;
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initWord(i);
      hdrCnt <= 0; wrCnt <= 0; rdBit <= 0; frameBits <= 0; lastFrameBits <= 0;
      busyLeft <= 0; hdrBits <= '0; lastHdr <= '0; wrBits <= '0;
      reading <= 1'b0; doReg <= 1'b0; rdAddr <= '0;
    end else begin
      if (busyLeft != 0) busyLeft <= busyLeft - 1;
      if (csP && !mwCs) begin
        lastFrameBits <= frameBits;
        lastHdr       <= hdrBits;
        frameBits <= 0; hdrCnt <= 0; wrCnt <= 0; reading <= 1'b0; doReg <= 1'b0;
        if (hdrCnt == 9 && hdrBits[7:6] == 2'b01 && wrCnt == 16) begin
          mem[hdrBits[5:0]] <= wrBits;
          busyLeft <= BUSY;
        end else if (hdrCnt == 9 && hdrBits[7:6] == 2'b11 && wrCnt == 0) begin
          mem[hdrBits[5:0]] <= 16'hFFFF;
          busyLeft <= BUSY;
        end
      end else if (mwCs && mwSk && !skP) begin
        frameBits <= frameBits + 1;
        if (hdrCnt < 9) begin
          hdrBits <= {hdrBits[7:0], mwDi};
          hdrCnt  <= hdrCnt + 1;
          if (hdrCnt == 8 && hdrBits[6:5] == 2'b10) begin
            reading <= 1'b1;
            rdAddr  <= {hdrBits[4:0], mwDi};
            rdBit   <= 0;
            doReg   <= 1'b0;   // filler bit ahead of the first word
          end
        end else if (reading) begin
          doReg <= mem[rdAddr][15 - rdBit];
          if (rdBit == 15) begin
            rdBit  <= 0;
            rdAddr <= rdAddr + 6'd1;
          end else begin
            rdBit <= rdBit + 1;
          end
        end else if (wrCnt < 16) begin
          wrBits <= {wrBits[14:0], mwDi};
          wrCnt  <= wrCnt + 1;
        end
      end
    end
  end

  // ---------------- pin monitors ----------------
  int lowCnt, lastLow, highCnt, badHigh, highRuns;
  always @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= 0; lastLow <= 0; highCnt <= 0; badHigh <= 0; highRuns <= 0;
    end else begin
      if (!mwCs) lowCnt <= lowCnt + 1;
      else begin
        if (lowCnt != 0) lastLow <= lowCnt;
        lowCnt <= 0;
      end
      if (mwSk) highCnt <= highCnt + 1;
      else if (highCnt != 0) begin
        highRuns <= highRuns + 1;
        if (highCnt != HALF) badHigh <= badHigh + 1;
        highCnt <= 0;
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] expMem [DEPTH];
  logic [15:0] got [16];
  int nGot;
  logic sawErr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic runCmd(input logic [1:0] op, input logic [5:0] addr,
                        input logic [15:0] data, input logic [7:0] count);
    int waitCyc;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data; reqCount = count;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 ready low while busy", 32'(reqReady), 32'd0);
    nGot = 0; sawErr = 1'b0; waitCyc = 0;
    while (!done && waitCyc < 5000) begin
      if (rdValid && nGot < 16) begin got[nGot] = rdData; nGot++; end
      @(negedge clk);
      waitCyc++;
    end
    if (rdValid && nGot < 16) begin got[nGot] = rdData; nGot++; end
    chk("R8 command completes", 32'(done), 32'd1);
    sawErr = timeoutErr;
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 32'd0);
    chk("R8 ready after done", 32'(reqReady), 32'd1);
  endtask

  task automatic checkCmd(input logic [1:0] op, input logic [5:0] addr,
                          input logic [15:0] data, input logic [7:0] count);
    int n;
    runCmd(op, addr, data, count);
    case (op)
      2'b10: begin
        n = (count == 0) ? 1 : int'(count);
        chk("R5 word count", 32'(nGot), 32'(n));
        for (int k = 0; k < n && k < nGot; k++)
          chk("R4 read word", 32'(got[k]), 32'(expMem[(int'(addr) + k) % DEPTH]));
        chk("R5 clocks in frame", 32'(lastFrameBits), 32'(9 + 16 * n));
        chk("R7 no timeout on read", 32'(sawErr), 32'd0);
      end
      2'b01, 2'b11: begin
        expMem[addr] = (op == 2'b01) ? data : 16'hFFFF;
        chk("R7 timeout flag", 32'(sawErr), 32'(stuck));
        chk("R6 deselect length", 32'(lastLow >= CS_MIN), 32'd1);
        chk("R5 no words on write", 32'(nGot), 32'd0);
      end
      default: begin
        chk("R9 header only", 32'(lastFrameBits), 32'd9);
        chk("R9 no words", 32'(nGot), 32'd0);
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) expMem[i] = initWord(i);
    repeat (4) @(negedge clk);
    chk("R1 cs low in reset", 32'(mwCs), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cs low", 32'(mwCs), 32'd0);
    chk("R1 sk low", 32'(mwSk), 32'd0);
    chk("R1 ready", 32'(reqReady), 32'd1);
    chk("R1 done low", 32'(done), 32'd0);
    chk("R1 rdValid low", 32'(rdValid), 32'd0);
    chk("R1 timeout low", 32'(timeoutErr), 32'd0);

    // R3: write then read back through the frame
    checkCmd(2'b01, 6'd5, 16'hA5C3, 8'd0);
    checkCmd(2'b10, 6'd5, 16'h0000, 8'd1);
    chk("R3 header of read", 32'(lastHdr), 32'({1'b1, 2'b10, 6'd5}));
    // R4: one-word read clock count includes only the shared filler slot
    chk("R4 one word clocks", 32'(lastFrameBits), 32'(3 + ADDR_W + DATA_W));
    // R5: erase top then wrap read
    checkCmd(2'b11, 6'd63, 16'h0000, 8'd0);
    checkCmd(2'b10, 6'd62, 16'h0000, 8'd3);
    chk("R5 wrapped word", 32'(got[2]), 32'(initWord(0)));
    checkCmd(2'b10, 6'd17, 16'h0000, 8'd0);
    // R9: header-only opcode
    checkCmd(2'b00, 6'h30, 16'hFFFF, 8'd0);
    chk("R9 header bits", 32'(lastHdr), 32'({1'b1, 2'b00, 6'h30}));
    // R7: memory never ready
    stuck = 1'b1;
    checkCmd(2'b01, 6'd9, 16'h1234, 8'd0);
    stuck = 1'b0;
    checkCmd(2'b10, 6'd9, 16'h0000, 8'd1);

    // mixed random traffic
    for (int t = 0; t < 24; t++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      checkCmd(op, 6'($urandom), 16'($urandom), 8'(1 + $urandom % 4));
    end

    // R2: serial clock high phases
    chk("R2 high phase length", 32'(badHigh), 32'd0);
    chk("R2 clock observed", 32'(highRuns > 100), 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule